// File: doc/BRIEF.md
# Indexed Host Register Access Port

This block gives an external host, which has only a 16-bit data bus and a few strobes, access to a bank of 32-bit internal registers. The host pulls its register-select pin high and writes an 8-bit index. The index holds a 6-bit register code and a 2-bit half pointer. The host then pulls the register-select pin low. Each following read or write of the data port reaches one 16-bit half of the register the index names.

A byte-order bit sets which 32-bit half a pointer value means. The bit is bit 0 of the control register, code 1. One register is a data window. Each completed access to it flips the half pointer, so a stream of data accesses walks through both halves with no new index write. Strobes are asynchronous to the system clock. Each access is synchronized and takes effect once, when its strobe is released. A plain register file stands in for the real peripheral registers. The internal CPU side has an index write input, and the block always refuses it.

Top module: `hreg_index_port`

## Requirements
- R1: After reset the index is 0x00 and every internal register is zero. A host read of the index then returns 0x0000.
- R2: With `host_sel` high, a host write loads the index from data bits 7..0. A host read returns the index in bits 7..0, with zeros in bits 15..8. The index layout is: bits 7..2 register code, bits 1..0 half pointer.
- R3: Register codes 0 to 6 select internal registers 0 to 6, and code 15 selects register 7, the buffer-control register. With `host_sel` low, a write to a selected half and a later read of that half return the written data.
- R4: The byte-order bit is bit 0 of register 1. When it is 0, half pointer 00 means bits 31..16 and 10 means bits 15..0. When it is 1, 00 means bits 15..0 and 10 means bits 31..16.
- R5: An access through any register code other than 0 to 6 or 15 is ignored on a write and returns 0x0000 on a read.
- R6: Half pointer values 01 and 11 are prohibited: writes are ignored and reads return 0x0000.
- R7: When the code is 6 (the data window) and the half pointer is valid, each completed data read or write flips the pointer between 00 and 10. The register code does not change.
- R8: Data accesses to any code other than 6, and prohibited accesses, leave the whole index unchanged.
- R9: The CPU-side index write input never changes the index. This holds even when it falls in the same cycle as a host index write, and in that case the host value is loaded.
- R10: An access takes effect exactly once, within four clocks after its strobe is released. A write uses the data present on the bus while the strobe was low. `host_dout` is 0x0000 whenever no read is active.
- R11: Strobes given while `host_cs_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_sel | input | 1 | High: the access targets the index; low: the access targets the indexed register |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Host read data, zero when no read is active |
| cpu_idx_we | input | 1 | CPU-side attempt to write the index (always refused) |
| cpu_idx_wdata | input | 8 | Data offered by the CPU side for the index |

## Verification
A CPU-side index write can fall in the same clock as the commit of a host index write. The bench holds `cpu_idx_we` high with an all-ones value for the whole length of a host index write, so the attempt covers the commit cycle. It then reads the index back and requires exactly the host's value. The other coincidence is a data-window access that carries a prohibited half code: the pointer advance and the rejection meet in one commit. The bench reads the index after such a strobe and requires it unchanged.

// File: rtl/hip_pkg.sv
package hip_pkg;

    localparam int CODE_W   = 6;
    localparam int HALF_W   = 2;
    localparam int IDX_W    = CODE_W + HALF_W;

    localparam logic [CODE_W-1:0] CODE_CTRL   = 6'd1;
    localparam logic [CODE_W-1:0] CODE_WINDOW = 6'd6;
    localparam logic [CODE_W-1:0] CODE_LAST   = 6'd6;
    localparam logic [CODE_W-1:0] CODE_BUFCTL = 6'd15;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [HALF_W-1:0] half;
    } idx_t;

    // Map a register code to a slot of the register file.
    function automatic logic [2:0] code_to_slot(input logic [CODE_W-1:0] code);
        if (code == CODE_BUFCTL) return 3'd7;
        return code[2:0];
    endfunction

    function automatic logic code_ok(input logic [CODE_W-1:0] code);
        return (code <= CODE_LAST) || (code == CODE_BUFCTL);
    endfunction

    function automatic logic half_ok(input logic [HALF_W-1:0] half);
        return half[0] == 1'b0;
    endfunction

endpackage

// File: rtl/hip_strobe_sync.sv
module hip_strobe_sync #(
    parameter int STAGES = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_din,
    output logic              commit_rd,
    output logic              commit_wr,
    output logic              acc_sel,
    output logic [DATA_W-1:0] acc_data
);

    localparam int BUS_W = DATA_W + 1;
    localparam int LAST  = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0]            rd_sh;
        logic [STAGES-1:0]            wr_sh;
        logic                         rd_prev;
        logic                         wr_prev;
        logic [STAGES-1:0][BUS_W-1:0] bus_sh;
        logic [BUS_W-1:0]             cap;
    } sync_t;

    sync_t s_d, s_q;
    logic  rd_act, wr_act;

    assign rd_act = ~host_rd_n & ~host_cs_n;
    assign wr_act = ~host_wr_n & ~host_cs_n;

    always_comb begin
        s_d = s_q;
        s_d.rd_sh[0]  = rd_act;
        s_d.wr_sh[0]  = wr_act;
        s_d.bus_sh[0] = {host_sel, host_din};
        for (int i = 1; i < STAGES; i++) begin
            s_d.rd_sh[i]  = s_q.rd_sh[i-1];
            s_d.wr_sh[i]  = s_q.wr_sh[i-1];
            s_d.bus_sh[i] = s_q.bus_sh[i-1];
        end
        s_d.rd_prev = s_q.rd_sh[LAST];
        s_d.wr_prev = s_q.wr_sh[LAST];
        if (s_q.rd_sh[LAST] || s_q.wr_sh[LAST]) begin
            s_d.cap = s_q.bus_sh[LAST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign commit_rd = s_q.rd_prev & ~s_q.rd_sh[LAST];
    assign commit_wr = s_q.wr_prev & ~s_q.wr_sh[LAST];
    assign acc_sel   = s_q.cap[BUS_W-1];
    assign acc_data  = s_q.cap[DATA_W-1:0];

    // R10
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> !commit_wr);
    // R10
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_rd, commit_wr}));
    // R10
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_rd || commit_wr) |=> $stable(acc_data));

endmodule

// File: rtl/hip_index_ctrl.sv
module hip_index_ctrl
    import hip_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_rd,
    input  logic             commit_wr,
    input  logic             acc_sel,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             cpu_idx_we,
    input  logic [IDX_W-1:0] cpu_idx_wdata,
    output idx_t             idx,
    output logic [2:0]       slot,
    output logic             access_ok
);

    typedef struct packed {
        idx_t idx;
    } ictl_t;

    ictl_t c_d, c_q;
    logic  host_load;
    logic  data_commit;
    logic  win_step;

    assign host_load   = commit_wr & acc_sel;
    assign data_commit = (commit_rd | commit_wr) & ~acc_sel;
    assign access_ok   = code_ok(c_q.idx.code) & half_ok(c_q.idx.half);
    assign win_step    = data_commit & access_ok & (c_q.idx.code == CODE_WINDOW);

    always_comb begin
        c_d = c_q;
        if (host_load) begin
            c_d.idx = idx_t'(acc_idx);
        end else if (win_step) begin
            c_d.idx.half[1] = ~c_q.idx.half[1];
        end
        // The CPU-side write input is deliberately not a term here.
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign idx  = c_q.idx;
    assign slot = code_to_slot(c_q.idx.code);

    // R9
    cpu_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_idx_we && !commit_rd && !commit_wr) |=> $stable(idx));
    // R9
    cpu_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_idx_we && !host_load && (cpu_idx_wdata != idx)) |=> (idx != $past(cpu_idx_wdata)));
    // R7
    window_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_commit && idx.code == CODE_WINDOW && idx.half[0] == 1'b0)
        |=> (idx.half[1] != $past(idx.half[1])) && $stable(idx.code));
    // R8
    other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_commit && (idx.code != CODE_WINDOW || idx.half[0])) |=> $stable(idx));

endmodule

// File: rtl/hip_regfile.sv
module hip_regfile #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [$clog2(NREG)-1:0]        slot,
    input  logic                           upper,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NREG-1:0][2*DATA_W-1:0]  regs
);

    localparam int REG_W = 2 * DATA_W;

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] r;
    } rf_t;

    rf_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        for (int i = 0; i < NREG; i++) begin
            if (we && slot == i[$clog2(NREG)-1:0]) begin
                if (upper) f_d.r[i][REG_W-1:DATA_W] = wdata;
                else       f_d.r[i][DATA_W-1:0]     = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign regs = f_q.r;

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs));
    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && upper) |=> regs[$past(slot)][REG_W-1:DATA_W] == $past(wdata));

endmodule

// File: rtl/hreg_index_port.sv
module hreg_index_port
    import hip_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    input  logic              cpu_idx_we,
    input  logic [IDX_W-1:0]  cpu_idx_wdata
);

    localparam int NREG  = 8;
    localparam int REG_W = 2 * DATA_W;

    logic                        commit_rd, commit_wr, acc_sel;
    logic [DATA_W-1:0]           acc_data;
    idx_t                        idx;
    logic [2:0]                  slot;
    logic                        access_ok;
    logic                        byte_order;
    logic                        upper;
    logic                        reg_we;
    logic                        rd_live;
    logic [NREG-1:0][REG_W-1:0]  regs;
    logic [DATA_W-1:0]           half_data;

    hip_strobe_sync #(
        .STAGES (SYNC_STAGES),
        .DATA_W (DATA_W)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_cs_n (host_cs_n),
        .host_rd_n (host_rd_n),
        .host_wr_n (host_wr_n),
        .host_sel  (host_sel),
        .host_din  (host_din),
        .commit_rd (commit_rd),
        .commit_wr (commit_wr),
        .acc_sel   (acc_sel),
        .acc_data  (acc_data)
    );

    hip_index_ctrl u_idx (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_rd     (commit_rd),
        .commit_wr     (commit_wr),
        .acc_sel       (acc_sel),
        .acc_idx       (acc_data[IDX_W-1:0]),
        .cpu_idx_we    (cpu_idx_we),
        .cpu_idx_wdata (cpu_idx_wdata),
        .idx           (idx),
        .slot          (slot),
        .access_ok     (access_ok)
    );

    assign byte_order = regs[CODE_CTRL[2:0]][0];
    assign upper      = (idx.half[1] == 1'b0) ^ byte_order;
    assign reg_we     = commit_wr & ~acc_sel & access_ok;

    hip_regfile #(
        .NREG   (NREG),
        .DATA_W (DATA_W)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .slot  (slot),
        .upper (upper),
        .wdata (acc_data),
        .regs  (regs)
    );

    assign rd_live   = ~host_cs_n & ~host_rd_n;
    assign half_data = upper ? regs[slot][REG_W-1:DATA_W] : regs[slot][DATA_W-1:0];

    always_comb begin
        host_dout = '0;
        if (rd_live) begin
            if (host_sel)       host_dout = DATA_W'(idx);
            else if (access_ok) host_dout = half_data;
        end
    end

    // R6
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr && !acc_sel && idx.half[0]) |=> $stable(regs));
    // R5
    bad_code_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_live && !host_sel && !code_ok(idx.code)) |-> host_dout == '0);
    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_live |-> host_dout == '0);

endmodule

// File: tb/hreg_index_port_tb.sv
module hreg_index_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic        host_sel = 1'b0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        cpu_idx_we = 1'b0;
    logic [7:0]  cpu_idx_wdata = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_reg [8];
    logic [7:0]  m_idx;

    always #2.5 clk = ~clk;

    hreg_index_port u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_cs_n     (host_cs_n),
        .host_rd_n     (host_rd_n),
        .host_wr_n     (host_wr_n),
        .host_sel      (host_sel),
        .host_din      (host_din),
        .host_dout     (host_dout),
        .cpu_idx_we    (cpu_idx_we),
        .cpu_idx_wdata (cpu_idx_wdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic m_valid(input logic [7:0] ix);
        return ((ix[7:2] <= 6'd6) || (ix[7:2] == 6'd15)) && !ix[0];
    endfunction

    function automatic int m_slot(input logic [7:0] ix);
        return (ix[7:2] == 6'd15) ? 7 : int'(ix[4:2]);
    endfunction

    function automatic logic m_upper(input logic [7:0] ix);
        return (ix[1] == 1'b0) ^ m_reg[1][0];
    endfunction

    function automatic logic [15:0] m_read(input logic [7:0] ix);
        if (!m_valid(ix)) return 16'h0000;
        return m_upper(ix) ? m_reg[m_slot(ix)][31:16] : m_reg[m_slot(ix)][15:0];
    endfunction

    task automatic m_step();
        if (m_valid(m_idx) && m_idx[7:2] == 6'd6) m_idx[1] = ~m_idx[1];
    endtask

    task automatic host_wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_cs_n = 1'b0; host_sel = sel; host_din = d;
        @(negedge clk); host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (sel) m_idx = d[7:0];
        else begin
            if (m_valid(m_idx)) begin
                if (m_upper(m_idx)) m_reg[m_slot(m_idx)][31:16] = d;
                else                m_reg[m_slot(m_idx)][15:0]  = d;
            end
            m_step();
        end
    endtask

    task automatic host_rd(input logic sel, output logic [15:0] d);
        @(negedge clk);
        host_cs_n = 1'b0; host_sel = sel;
        @(negedge clk); host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        d = host_dout;
        host_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (!sel) m_step();
    endtask

    task automatic set_idx(input logic [5:0] code, input logic [1:0] half);
        host_wr(1'b1, {8'h00, code, half});
    endtask

    // Write the control register's low half so the byte-order bit takes value b.
    task automatic set_order(input logic b);
        logic [1:0] h;
        h = m_reg[1][0] ? 2'b00 : 2'b10;
        set_idx(6'd1, h);
        host_wr(1'b0, {m_reg[1][15:1], b});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_idx = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        host_rd(1'b1, v); chk("R1 index after reset", v, 16'h0000);
        host_rd(1'b0, v); chk("R1 reg0 after reset", v, 16'h0000);
        m_idx = 8'h00;
        // R10 idle bus
        chk("R10 idle dout", host_dout, 16'h0000);

        // R3 R4 R5 R6 R2 sweep over both byte orders, all codes and half values
        for (int bo = 0; bo < 2; bo++) begin
            set_order(bo[0]);
            for (int code = 0; code < 16; code++) begin
                for (int h = 0; h < 4; h++) begin
                    logic [15:0] pat;
                    logic [7:0]  ix;
                    ix  = {code[5:0], h[1:0]};
                    pat = {code[3:0], h[1:0], bo[0], 1'b1, 8'hA5} ^ {8'h00, ix};
                    if (code == 1) pat[0] = bo[0];
                    set_idx(code[5:0], h[1:0]);
                    host_rd(1'b1, v); chk("R2 index readback", v, {8'h00, m_idx});
                    host_wr(1'b0, pat);
                    host_rd(1'b1, v); chk("R7 R8 index after write", v, {8'h00, m_idx});
                    set_idx(code[5:0], h[1:0]);
                    begin
                        logic [15:0] e;
                        e = m_read(m_idx);
                        host_rd(1'b0, v);
                        chk(m_valid(ix) ? "R3 R4 data readback" : "R5 R6 prohibited read", v, e);
                    end
                    host_rd(1'b1, v); chk("R7 R8 index after read", v, {8'h00, m_idx});
                end
            end
        end

        // R4 explicit word assembly across byte orders
        set_order(1'b0);
        set_idx(6'd3, 2'b00); host_wr(1'b0, 16'h1111);
        set_idx(6'd3, 2'b10); host_wr(1'b0, 16'h2222);
        set_order(1'b1);
        set_idx(6'd3, 2'b00); host_rd(1'b0, v); chk("R4 order1 half00 is low", v, 16'h2222);
        set_idx(6'd3, 2'b10); host_rd(1'b0, v); chk("R4 order1 half10 is high", v, 16'h1111);
        set_order(1'b0);

        // R7 window sequence over consecutive data accesses
        set_idx(6'd6, 2'b00);
        for (int k = 0; k < 6; k++) begin
            host_wr(1'b0, 16'h0100 + 16'(k));
            host_rd(1'b1, v);
            chk("R7 window pointer", v, (k % 2 == 0) ? 16'h001A : 16'h0018);
        end
        set_idx(6'd6, 2'b00); host_rd(1'b0, v); chk("R7 window high", v, 16'h0104);
        host_rd(1'b0, v); chk("R7 window low", v, 16'h0105);
        host_rd(1'b1, v); chk("R7 window after two reads", v, 16'h0018);

        // R6 R8 prohibited half on window does not advance
        set_idx(6'd6, 2'b01); host_wr(1'b0, 16'hDEAD);
        host_rd(1'b1, v); chk("R8 window bad half keeps index", v, 16'h0019);

        // R9 CPU-side write alone and overlapping a host index write
        set_idx(6'd2, 2'b10);
        @(negedge clk); cpu_idx_we = 1'b1; cpu_idx_wdata = 8'hFF;
        repeat (5) @(negedge clk); cpu_idx_we = 1'b0;
        host_rd(1'b1, v); chk("R9 cpu write refused", v, 16'h000A);
        @(negedge clk); cpu_idx_we = 1'b1;
        host_wr(1'b1, 16'h0010);
        cpu_idx_we = 1'b0;
        host_rd(1'b1, v); chk("R9 host wins over cpu", v, 16'h0010);

        // R11 strobe without chip select
        set_idx(6'd4, 2'b00); host_wr(1'b0, 16'h4444);
        @(negedge clk); host_sel = 1'b1; host_din = 16'h00FC;
        host_wr_n = 1'b0; repeat (4) @(negedge clk); host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        host_rd(1'b1, v); chk("R11 no cs index", v, 16'h0010);
        host_rd(1'b0, v); chk("R11 no cs data", v, 16'h4444);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule